// File: doc/BRIEF.md
# Bit-Serial Halfword Concatenator with Constant-Four Source

This block sits in the datapath of a 32-bit processor that moves every word one bit per clock, least significant bit first. A free-running phase counter numbers the bit positions of a word from 0 to 31. Two serial operand streams, A and B, arrive in step with that count. The block produces one serial result word: its low half is A's low 16 bits and its high half is B's low 16 bits. It does this without a parallel register or a shifter. B passes through a 16-stage delay line, and a selector driven by the top bit of the phase count picks between the delayed B stream and the live A stream. This lets a 32-bit immediate be built from two 16-bit halves.

On the same phase timing the block also emits a serial stream that carries the constant 0x00000004 in every word. The processor uses it to step the program counter and as a fixed interrupt vector. Both outputs are combinational functions of the current phase and the current or delayed input bits, so they are valid in the clock of their phase. The phase count is brought out so that neighbouring serial units can stay aligned with it.

Top module: `bsc_concat_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the phase count becomes 0. The cycle in which `rst_n` is first seen high carries phase 0, bit 0 of a new word.
- R2: Outside reset, the phase count rises by one at every clock edge and wraps from 31 to 0 with no idle cycle.
- R3: In phases 0 to 15, `cat_bit` equals `a_bit` of the same cycle. This makes result bits 0-15 equal A bits 0-15.
- R4: In phases 16 to 31, `cat_bit` equals the `b_bit` driven 16 clocks earlier. This makes result bit n equal B bit n-16.
- R5: The B bits driven in phases 16 to 31 have no effect on the result of that word or of the next word.
- R6: The A bits driven in phases 16 to 31 have no effect on the result.
- R7: `four_bit` is 1 in phase 2 only. The serial word it carries is therefore 0x00000004 in every word.
- R8: Words may follow one another with no gap, each with different operands, and every word is assembled correctly.
- R9: A reset applied in the middle of a word restarts the phase at 0, and the next full word is assembled correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_bit | input | 1 | Serial A operand bit for the current phase |
| b_bit | input | 1 | Serial B operand bit for the current phase |
| phase | output | 5 | Current bit position within the word (0 = least significant) |
| cat_bit | output | 1 | Serial concatenation result bit |
| four_bit | output | 1 | Serial constant-four bit |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 16-stage delay line and the constant 4. These defaults reach every phase boundary that matters. They cover the switch of the selector between phases 15 and 16, the wrap from 31 to 0, the single lit phase of the constant stream, and the carry-over of stale upper-half B bits into the next word. With a 16-bit half, a full-width pattern in every field shows that no bit leaks across the boundary. The back-to-back runs then show that the delay line bridges word edges without a gap.

// File: rtl/bsc_pkg.sv
// Package bsc_pkg
// Shared constants and helpers for the bit-serial concatenator.
// Assumes words are a power of two bits wide and at least 4 bits.
package bsc_pkg;

    // Default serial word width used across the unit.
    localparam int unsigned BSC_WORD_W = 32;

    // Default constant carried by the constant stream.
    localparam logic [BSC_WORD_W-1:0] BSC_CONST = 32'h0000_0004;

    // Number of phase bits needed for a word of the given width.
    function automatic int unsigned bsc_phase_bits(input int unsigned word_w);
        return (word_w <= 2) ? 1 : $clog2(word_w);
    endfunction

endpackage

// File: rtl/bsc_phase_ctr.sv
// Module bsc_phase_ctr
// Counts the bit position of the serial word, 0 to WORD_W-1, and wraps
// with no gap. Assumes a synchronous active-low reset that forces phase 0.
module bsc_phase_ctr #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned PH_W   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase
);
    localparam logic [PH_W-1:0] LAST = PH_W'(WORD_W - 1);

    // Advance the bit position every clock, returning to 0 after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (phase == LAST)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    // R1: a reset cycle leaves the count at zero.
    a_r1_reset_phase: assert property (@(posedge clk)
        !rst_n |=> (phase == '0));

    // R2: outside reset, the count steps by exactly one per clock.
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && phase != LAST) |=> (phase == $past(phase) + 1'b1));

    // R2: the wrap goes straight from the last bit to bit 0.
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == LAST) |=> (phase == '0));

endmodule

// File: rtl/bsc_delay_line.sv
// Module bsc_delay_line
// A DEPTH-stage shift register that takes the serial input every clock.
// Its tail bit is the input from DEPTH clocks earlier. Assumes it shifts
// without pause, so at phase DEPTH it holds the first DEPTH bits of the word.
module bsc_delay_line #(
    parameter int unsigned DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic tail
);
    logic [DEPTH-1:0] stages;

    // Shift the input in at the top, so the oldest bit reaches position 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stages <= '0;
        else
            stages <= {din, stages[DEPTH-1:1]};
    end

    // Present the oldest stored bit.
    always_comb tail = stages[0];

    // R4: the bit at the head of the line is the input taken one clock before.
    a_r4_head_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (stages[DEPTH-1] == $past(din)));

endmodule

// File: rtl/bsc_const_gen.sv
// Module bsc_const_gen
// Emits a constant serially, least significant bit first, by selecting
// the bit of CONST_VAL that matches the current phase.
// Assumes the phase counter runs without gaps.
module bsc_const_gen #(
    parameter int unsigned           WORD_W    = 32,
    parameter int unsigned           PH_W      = 5,
    parameter logic [WORD_W-1:0]     CONST_VAL = 32'h4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] phase,
    output logic            const_bit
);
    localparam logic [PH_W-1:0] LAST = PH_W'(WORD_W - 1);
    localparam int unsigned     ONES = $countones(CONST_VAL);

    // Pick the constant bit for this bit position.
    always_comb const_bit = CONST_VAL[phase];

    // Count lit phases within the word; this count is used only by the check below.
    logic [PH_W:0] ones_seen;
    always_ff @(posedge clk) begin
        if (!rst_n || phase == LAST)
            ones_seen <= '0;
        else
            ones_seen <= ones_seen + {{PH_W{1'b0}}, const_bit};
    end

    // R7: every word carries exactly as many ones as the constant.
    a_r7_ones_per_word: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == LAST) |-> ((ones_seen + {{PH_W{1'b0}}, const_bit}) == (PH_W+1)'(ONES)));

endmodule

// File: rtl/bsc_concat_top.sv
// Module bsc_concat_top
// Bit-serial halfword concatenator with a constant stream.
// The result word carries A's low half in its low half and B's low half
// in its high half. B is delayed by half a word, and the top phase bit
// selects the source. Assumes both operands arrive LSB first, in step
// with the phase output, and that reset is synchronous and active low.
module bsc_concat_top #(
    parameter  int unsigned        WORD_W    = bsc_pkg::BSC_WORD_W,
    parameter  logic [WORD_W-1:0]  CONST_VAL = bsc_pkg::BSC_CONST,
    localparam int unsigned        PH_W      = bsc_pkg::bsc_phase_bits(WORD_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            a_bit,
    input  logic            b_bit,
    output logic [PH_W-1:0] phase,
    output logic            cat_bit,
    output logic            four_bit
);
    localparam int unsigned HALF_W = WORD_W / 2;

    logic b_delayed;
    logic upper_half;

    bsc_phase_ctr #(.WORD_W(WORD_W), .PH_W(PH_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    bsc_delay_line #(.DEPTH(HALF_W)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (b_bit),
        .tail  (b_delayed)
    );

    bsc_const_gen #(.WORD_W(WORD_W), .PH_W(PH_W), .CONST_VAL(CONST_VAL)) u_const (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .const_bit (four_bit)
    );

    // The top phase bit alone marks the upper half of the word.
    always_comb upper_half = phase[PH_W-1];

    // Route live A in the lower half and delayed B in the upper half.
    always_comb cat_bit = upper_half ? b_delayed : a_bit;

    // R3: in the lower half, the result follows the live A stream.
    a_r3_low_passes_a: assert property (@(posedge clk) disable iff (!rst_n)
        (phase < PH_W'(HALF_W)) |-> (cat_bit == a_bit));

endmodule

// File: tb/tb_bsc_concat_top.sv
`timescale 1ns/1ps
module tb_bsc_concat_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a_bit = 1'b0;
    logic       b_bit = 1'b0;
    logic [4:0] phase;
    logic       cat_bit;
    logic       four_bit;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bsc_concat_top dut (
        .clk(clk), .rst_n(rst_n), .a_bit(a_bit), .b_bit(b_bit),
        .phase(phase), .cat_bit(cat_bit), .four_bit(four_bit)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // R1: hold reset, check the reset state, release at a falling edge.
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        a_bit = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check("R1", "phase in reset", {27'd0, phase}, 32'd0);
        check("R7", "four in reset (phase 0)", {31'd0, four_bit}, 32'd0);
        check("R3", "cat follows a in reset", {31'd0, cat_bit}, 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Run one word from phase 0 and check the result, the constant and the phase walk.
    task automatic t_word(input string req, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] res = '0;
        logic [31:0] four = '0;
        logic        ph_ok = 1'b1;
        for (int i = 0; i < 32; i++) begin
            a_bit = a[i];
            b_bit = b[i];
            #1;
            res[i]  = cat_bit;
            four[i] = four_bit;
            if (phase != 5'(i)) ph_ok = 1'b0;
            @(negedge clk);
        end
        check(req, "result word", res, {b[15:0], a[15:0]});
        check("R7", "constant word", four, 32'h0000_0004);
        check("R2", "phase walk", {31'd0, ph_ok}, 32'd1);
    endtask

    // R9: stop a word part-way, reset, then run a clean word.
    task automatic t_mid_reset();
        for (int i = 0; i < 11; i++) begin
            b_bit = 1'b1;
            a_bit = 1'b0;
            @(negedge clk);
        end
        t_reset();
        #1;
        check("R9", "phase after mid-word reset", {27'd0, phase}, 32'd0);
        t_word("R9", 32'h0000_1357, 32'h0000_2468);
    endtask

    initial begin : main
        fork
            begin
                t_reset();
                t_word("R3", 32'h0000_0000, 32'h0000_0000);
                t_word("R4", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
                t_word("R4", 32'h0000_A5C3, 32'h0000_3C5A);
                // R5: upper-half B bits are all ones and must not appear in this word or the next.
                t_word("R5", 32'h0000_0001, 32'hFFFF_8000);
                t_word("R5", 32'h0000_8001, 32'h0000_0000);
                // R6: upper-half A bits are all ones and must be ignored.
                t_word("R6", 32'hFFFF_0000, 32'h0000_0001);
                // R8: back-to-back words with no gap and changing operands; the last one wraps the phase.
                for (int w = 0; w < 4; w++)
                    t_word("R8", 32'h1234_0000 ^ (32'h1111 * (w + 1)),
                                 32'h8765_0000 ^ (32'h0F0F << w));
                t_mid_reset();
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog timeout");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule